// File: doc/BRIEF.md
# Picture Temporal Reference Counter

This block keeps the 5-bit temporal reference that a video encoder places in each picture header. The counter advances on a strobe, and a 3-bit source select picks where that strobe comes from. It can count frames the encoder has actually coded. It can count frames from an internal fractional-rate divider running at 30000/1001 Hz. It can count rising edges of an asynchronous frame strobe pin. In host mode the counter does not count: a host-written value replaces it outright.

The live count is always visible. A one-cycle picture-start pulse copies the count into a header register, which the header serialiser reads for the duration of the picture. A select code with no defined meaning freezes the counter and raises an error flag. All pins are plain level or pulse controls. There is no streamed data path, so no valid/ready handshake is needed and nothing can apply back-pressure.

Top module: `tref_counter`

## Requirements
- R1: After reset `tr_count` and `tr_hdr` are 0 and `src_err` is 0.
- R2: When `src_sel[2]` is 0 (host mode, select codes 000 to 011), `tr_count` takes the value of `host_tr` at every clock edge, whatever the strobe inputs do.
- R3: With `src_sel` = 100, `tr_count` increases by one at each clock edge where `frame_coded` is high.
- R4: With `src_sel` = 101, an internal accumulator adds `RATE_NUM` per clock and ticks when it reaches `CLK_HZ*RATE_DEN`, keeping the remainder. The accumulator is cleared whenever another select is active. With `CLK_HZ`=3000 the first increment comes 101 edges after entering the mode, and there are exactly 10 increments in the first 1001 edges.
- R5: With `src_sel` = 110, `fs_pin` passes through a two-stage synchroniser and a rising-edge detector. Each low-to-high transition gives exactly one increment, on the third clock edge after the pin rises. A pin held high gives no further increments.
- R6: With `src_sel` = 111, `tr_count` holds its value. `src_err` is 1 from the edge after the code is applied until the edge after it is removed.
- R7: The count wraps from 31 to 0.
- R8: On a clock edge where `pic_start` is high, `tr_hdr` takes the value `tr_count` had before that edge. At all other edges `tr_hdr` holds its value.
- R9: Strobes from sources other than the selected one do not change `tr_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider time base |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Strobe source select (0XX host, 100 coded, 101 divider, 110 pin, 111 illegal) |
| host_tr | input | 5 | Host-written reference value used in host mode |
| frame_coded | input | 1 | One pulse per coded frame, synchronous |
| fs_pin | input | 1 | Asynchronous external frame strobe |
| pic_start | input | 1 | Picture start pulse that latches the header value |
| tr_count | output | 5 | Live temporal reference counter |
| tr_hdr | output | 5 | Temporal reference latched at picture start |
| src_err | output | 1 | High while the illegal select code is applied |

## Verification
Every counter state is visible on `tr_count` one edge after the cause. A wrong mode decode or a missed or doubled increment therefore shows on the next sample. The only slow error is a wrong divider ratio, and it shows within roughly one hundred cycles as a misplaced first tick or a wrong tally over a 1001-cycle window. A synchroniser of the wrong depth shows as the pin increment arriving one edge early or late. A stuck header latch shows the first time `pic_start` pulses or the count moves without it.

// File: rtl/tref_pkg.sv
`timescale 1ns/1ps
package tref_pkg;

  typedef enum logic [2:0] {
    SRC_HOST    = 3'd0,
    SRC_CODED   = 3'd1,
    SRC_DIVIDER = 3'd2,
    SRC_PIN     = 3'd3,
    SRC_BAD     = 3'd4
  } tref_src_e;

  // Host mode when the top select bit is clear; the rest are decoded fully.
  function automatic tref_src_e decode_src(input logic [2:0] code);
    tref_src_e res;
    if (!code[2]) begin
      res = SRC_HOST;
    end else begin
      case (code[1:0])
        2'b00:   res = SRC_CODED;
        2'b01:   res = SRC_DIVIDER;
        2'b10:   res = SRC_PIN;
        default: res = SRC_BAD;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/tref_rate_div.sv
`timescale 1ns/1ps
module tref_rate_div #(
  parameter int unsigned CLK_HZ   = 27_000_000,
  parameter int unsigned RATE_NUM = 30000,
  parameter int unsigned RATE_DEN = 1001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam logic [63:0] THR64 = 64'(CLK_HZ) * 64'(RATE_DEN);
  localparam int ACC_W = $clog2(THR64) + 1;
  localparam logic [ACC_W-1:0] THR = ACC_W'(THR64);
  localparam logic [ACC_W-1:0] INC = ACC_W'(RATE_NUM);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, INC};
    tick = run && (sum >= {1'b0, THR});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      acc_q <= '0;
    end else if (tick) begin
      acc_q <= ACC_W'(sum - {1'b0, THR});
    end else begin
      acc_q <= ACC_W'(sum);
    end
  end
endmodule

// File: rtl/tref_pin_edge.sv
`timescale 1ns/1ps
module tref_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  generate
    for (genvar g = 0; g < SH_W; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sh_q[g] <= 1'b0;
        end else if (g == 0) begin
          sh_q[g] <= pin;
        end else begin
          sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/tref_count_core.sv
`timescale 1ns/1ps
module tref_count_core
  import tref_pkg::*;
#(
  parameter int TR_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tref_src_e       src,
  input  logic [TR_W-1:0] host_val,
  input  logic            step,
  input  logic            pic_start,
  output logic [TR_W-1:0] count,
  output logic [TR_W-1:0] hdr,
  output logic            err
);
  logic [TR_W-1:0] count_d;

  always_comb begin
    count_d = count;
    unique case (src)
      SRC_HOST: count_d = host_val;
      SRC_BAD:  count_d = count;
      default:  if (step) count_d = count + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      hdr   <= '0;
      err   <= 1'b0;
    end else begin
      count <= count_d;
      err   <= (src == SRC_BAD);
      if (pic_start) hdr <= count;
    end
  end
endmodule

// File: rtl/tref_counter.sv
`timescale 1ns/1ps
module tref_counter
  import tref_pkg::*;
#(
  parameter int          TR_W        = 5,
  parameter int unsigned CLK_HZ      = 27_000_000,
  parameter int unsigned RATE_NUM    = 30000,
  parameter int unsigned RATE_DEN    = 1001,
  parameter int          SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      src_sel,
  input  logic [TR_W-1:0] host_tr,
  input  logic            frame_coded,
  input  logic            fs_pin,
  input  logic            pic_start,
  output logic [TR_W-1:0] tr_count,
  output logic [TR_W-1:0] tr_hdr,
  output logic            src_err
);
  tref_src_e src;
  logic      div_tick;
  logic      pin_rise;
  logic      step;

  assign src = decode_src(src_sel);

  tref_rate_div #(
    .CLK_HZ  (CLK_HZ),
    .RATE_NUM(RATE_NUM),
    .RATE_DEN(RATE_DEN)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (src == SRC_DIVIDER),
    .tick (div_tick)
  );

  tref_pin_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pin (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (fs_pin),
    .rise (pin_rise)
  );

  always_comb begin
    case (src)
      SRC_CODED:   step = frame_coded;
      SRC_DIVIDER: step = div_tick;
      SRC_PIN:     step = pin_rise;
      default:     step = 1'b0;
    endcase
  end

  tref_count_core #(
    .TR_W(TR_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .host_val (host_tr),
    .step     (step),
    .pic_start(pic_start),
    .count    (tr_count),
    .hdr      (tr_hdr),
    .err      (src_err)
  );
endmodule

// File: rtl/tref_checker.sv
`timescale 1ns/1ps
module tref_checker #(
  parameter int TR_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      src_sel,
  input logic [TR_W-1:0] host_tr,
  input logic            frame_coded,
  input logic            pic_start,
  input logic [TR_W-1:0] tr_count,
  input logic [TR_W-1:0] tr_hdr,
  input logic            src_err
);
  assert_host_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !src_sel[2] |=> tr_count == $past(host_tr));

  assert_coded_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b100 && frame_coded) |=> tr_count == TR_W'($past(tr_count) + 1'b1));

  assert_coded_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b100 && !frame_coded) |=> $stable(tr_count));

  assert_pin_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b110) |=> (tr_count == $past(tr_count) ||
                             tr_count == TR_W'($past(tr_count) + 1'b1)));

  assert_bad_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b111) |=> ($stable(tr_count) && src_err));

  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != 3'b111) |=> !src_err);

  assert_hdr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pic_start |=> $stable(tr_hdr));

  assert_hdr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pic_start |=> tr_hdr == $past(tr_count));
endmodule

bind tref_counter tref_checker #(.TR_W(TR_W)) u_tref_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_sel    (src_sel),
  .host_tr    (host_tr),
  .frame_coded(frame_coded),
  .pic_start  (pic_start),
  .tr_count   (tr_count),
  .tr_hdr     (tr_hdr),
  .src_err    (src_err)
);

// File: tb/tref_counter_bench.sv
`timescale 1ns/1ps
module tref_counter_bench;
  localparam int TR_W = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      src_sel = 3'b000;
  logic [TR_W-1:0] host_tr = '0;
  logic            frame_coded = 1'b0;
  logic            fs_pin = 1'b0;
  logic            pic_start = 1'b0;
  logic [TR_W-1:0] tr_count;
  logic [TR_W-1:0] tr_hdr;
  logic            src_err;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  tref_counter #(
    .TR_W(TR_W), .CLK_HZ(3000), .RATE_NUM(30000), .RATE_DEN(1001), .SYNC_STAGES(2)
  ) u_tref_counter (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .host_tr(host_tr),
    .frame_coded(frame_coded), .fs_pin(fs_pin), .pic_start(pic_start),
    .tr_count(tr_count), .tr_hdr(tr_hdr), .src_err(src_err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(3);
    check("R1 count", int'(tr_count), 0);
    check("R1 hdr", int'(tr_hdr), 0);
    check("R1 err", int'(src_err), 0);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_host;
    src_sel = 3'b010; host_tr = 5'd12;
    step(1);
    check("R2 load", int'(tr_count), 12);
    frame_coded = 1'b1; fs_pin = 1'b1;
    step(1);
    frame_coded = 1'b0;
    step(4);
    check("R2 strobes ignored", int'(tr_count), 12);
    fs_pin = 1'b0;
    host_tr = 5'd3;
    step(1);
    check("R2 reload", int'(tr_count), 3);
  endtask

  task automatic t_coded;
    src_sel = 3'b100;
    step(2);
    check("R3 no pulse", int'(tr_count), 3);
    frame_coded = 1'b1;
    step(1);
    frame_coded = 1'b0;
    check("R3 one pulse", int'(tr_count), 4);
    frame_coded = 1'b1;
    step(3);
    frame_coded = 1'b0;
    step(1);
    check("R3 three pulses", int'(tr_count), 7);
  endtask

  task automatic t_wrap;
    src_sel = 3'b000; host_tr = 5'd30;
    step(1);
    src_sel = 3'b100; frame_coded = 1'b1;
    step(3);
    frame_coded = 1'b0;
    check("R7 wrap", int'(tr_count), 1);
  endtask

  task automatic t_divider;
    src_sel = 3'b000; host_tr = 5'd5;
    step(1);
    src_sel = 3'b101;
    step(100);
    check("R4 before first tick", int'(tr_count), 5);
    step(1);
    check("R4 first tick", int'(tr_count), 6);
    step(900);
    check("R4 ten ticks", int'(tr_count), 15);
  endtask

  task automatic t_pin;
    src_sel = 3'b000; host_tr = 5'd20;
    step(1);
    src_sel = 3'b110;
    step(4);
    fs_pin = 1'b1;
    step(2);
    check("R5 not yet", int'(tr_count), 20);
    step(1);
    check("R5 rise", int'(tr_count), 21);
    step(6);
    check("R5 held high", int'(tr_count), 21);
    fs_pin = 1'b0;
    frame_coded = 1'b1;
    step(1);
    frame_coded = 1'b0;
    step(4);
    check("R9 coded ignored in pin mode", int'(tr_count), 21);
    fs_pin = 1'b1;
    step(5);
    fs_pin = 1'b0;
    step(5);
    check("R5 second rise", int'(tr_count), 22);
  endtask

  task automatic t_bad;
    src_sel = 3'b111;
    step(1);
    check("R6 err", int'(src_err), 1);
    frame_coded = 1'b1; fs_pin = 1'b1; host_tr = 5'd0;
    step(6);
    frame_coded = 1'b0; fs_pin = 1'b0;
    step(3);
    check("R6 hold", int'(tr_count), 22);
    src_sel = 3'b100;
    step(1);
    check("R6 err clears", int'(src_err), 0);
    check("R9 no carry-over", int'(tr_count), 22);
  endtask

  task automatic t_latch;
    src_sel = 3'b000; host_tr = 5'd9;
    step(2);
    check("R8 hdr held", int'(tr_hdr), 0);
    pic_start = 1'b1; host_tr = 5'd17;
    step(1);
    pic_start = 1'b0;
    check("R8 captured", int'(tr_hdr), 9);
    step(3);
    check("R8 hold after", int'(tr_hdr), 9);
    check("R2 live value", int'(tr_count), 17);
  endtask

  initial begin
    step(1);
    t_reset;
    t_host;
    t_coded;
    t_wrap;
    t_divider;
    t_pin;
    t_bad;
    t_latch;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule